// File: doc/BRIEF.md
# Video-Mode Frame Timing Generator

This block paces the video stream of a serial display link. A horizontal counter advances once per lane-byte clock and a vertical counter advances once per line. Every line is divided into a sync-active stretch, a back porch, an active stretch and a front porch. The frame is divided the same way, but in whole lines. From these two counters the block produces one-cycle markers where a downstream packetizer would emit sync-start and sync-end packets. It also produces a data-valid flag with a pixel index for the payload, and a blanking flag for the rest of the line.

The line period, sync width and back porch are programmed in byte clocks. The front porch is never programmed: it is whatever is left of the line. Three pacing variants are selectable:
- The pulse variant emits both sync start and sync end.
- The event variant emits sync start only.
- The burst variant sends each line's pixels two per byte clock, which lengthens the blanking that follows.

All settings are captured into shadow registers when the generator is enabled and again at each frame boundary. Software can therefore rewrite them at any time without tearing a frame.

Top module: `vid_timing_gen`

## Requirements
- R1: While disabled (or in reset) every strobe, `pix_valid_o`, `blank_o` and `cfg_err_o` are 0, and `hsync_o`/`vsync_o` sit at their inactive level (1 when the matching `cfg_*_low` is set, else 0).
- R2: The horizontal position h counts byte clocks from 0. `line_start_o` and `hs_start_o` pulse at h=0. `hsync_o` is active for h < HSA. `hs_end_o` pulses at h=HSA, except in the event variant.
- R3: A line lasts exactly `cfg_hline` byte clocks when that covers HSA+HBP+active length. The front porch is the remainder.
- R4: In the non-burst variants (`cfg_mode` 00 pulse, 01 event), `pix_valid_o` is high for `cfg_pkt` cycles starting at h=HSA+HBP, on active lines only. `pix_cnt_o` runs 0,1,2,... during this stretch. `blank_o` is high on every other enabled cycle.
- R5: In the burst variant (`cfg_mode` 10 or 11), the active stretch lasts ceil(`cfg_pkt`/2) cycles and `pix_cnt_o` steps 0,2,4,...
- R6: In the event variant (`cfg_mode`=01), `hs_end_o` and `vs_end_o` never pulse.
- R7: A frame has VSA+VBP+VACT+VFP lines. `frame_start_o` and `vs_start_o` pulse at line 0, h=0. `vs_end_o` pulses at h=0 of line VSA. `vsync_o` is active on lines below VSA. Active lines are VSA+VBP up to VSA+VBP+VACT-1.
- R8: A vertical sync width above 15 lines is treated as 15.
- R9: `cfg_hs_low`=1 makes `hsync_o` active-low. `cfg_vs_low`=1 makes `vsync_o` active-low.
- R10: Settings take effect only at the first enabled cycle and at each frame start. A change made mid-frame does not alter the current frame.
- R11: If `cfg_hline` < HSA+HBP+active length, the line is stretched to exactly that sum, which leaves a zero front porch, and `cfg_err_o` is 1 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | lane-byte clock |
| rst_n | input | 1 | asynchronous active-low reset |
| enable | input | 1 | run the generator; low clears the counters |
| cfg_hsa | input | HW | horizontal sync width, byte clocks |
| cfg_hbp | input | HW | horizontal back porch, byte clocks |
| cfg_hline | input | HW | total line period, byte clocks |
| cfg_vsa | input | VW | vertical sync width, lines |
| cfg_vbp | input | VW | vertical back porch, lines |
| cfg_vfp | input | VW | vertical front porch, lines |
| cfg_vact | input | VW | active lines |
| cfg_pkt | input | PW | pixels per active line |
| cfg_mode | input | 2 | 00 pulse, 01 event, 1x burst |
| cfg_hs_low | input | 1 | hsync active-low |
| cfg_vs_low | input | 1 | vsync active-low |
| frame_start_o | output | 1 | first cycle of a frame |
| line_start_o | output | 1 | first cycle of a line |
| hs_start_o | output | 1 | horizontal sync start |
| hs_end_o | output | 1 | horizontal sync end |
| vs_start_o | output | 1 | vertical sync start |
| vs_end_o | output | 1 | vertical sync end |
| hsync_o | output | 1 | horizontal sync level |
| vsync_o | output | 1 | vertical sync level |
| pix_valid_o | output | 1 | active payload cycle |
| pix_cnt_o | output | PW | index of first pixel in this cycle |
| blank_o | output | 1 | enabled cycle outside the payload |
| cfg_err_o | output | 1 | line period too short for the payload |

## Verification
Two functions can land in the same cycle. The first is the frame-boundary reload of the shadow settings; the second is the first cycle of the new frame's timing, which must already use the new values. The bench provokes this by rewriting the line period in the middle of a frame. It then judges that the current frame still totals the old length and that the very next line already has the new length. The second collision is at the tail of a line: in an overrun configuration the last payload cycle and the line wrap share a cycle, and the bench checks that the measured line period equals the payload end exactly while the error flag is raised.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    VM_PULSE = 2'b00,
    VM_EVENT = 2'b01,
    VM_BURST = 2'b10,
    VM_BURST2 = 2'b11
  } vmode_e;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [HW-1:0]    cfg_hsa,
  input  logic [HW-1:0]    cfg_hbp,
  input  logic [HW-1:0]    cfg_hline,
  input  logic [VW-1:0]    cfg_vsa,
  input  logic [VW-1:0]    cfg_vbp,
  input  logic [VW-1:0]    cfg_vfp,
  input  logic [VW-1:0]    cfg_vact,
  input  logic [PW-1:0]    cfg_pkt,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_hs_low,
  input  logic             cfg_vs_low,
  output logic [HW-1:0]    sh_hsa,
  output logic [HW+1:0]    sh_act_s,
  output logic [HW+1:0]    sh_act_e,
  output logic [HW+1:0]    sh_len,
  output logic             sh_err,
  output logic [VW-1:0]    sh_vsa,
  output logic [VW+1:0]    sh_vact_s,
  output logic [VW+1:0]    sh_vact_e,
  output logic [VW+1:0]    sh_vtot,
  output vmode_e           sh_mode,
  output logic             sh_hs_low,
  output logic             sh_vs_low
);
  localparam int HCW = HW + 2;
  localparam int VCW = VW + 2;
  localparam logic [VW-1:0] VSA_MAX = VW'(15);

  logic [HCW-1:0] alen, act_s_d, act_e_d, len_d, hl;
  logic           err_d;
  logic [VW-1:0]  vsa_d;
  logic [VCW-1:0] vas_d, vae_d, vtot_d;

  // next-state: derived geometry of the pending frame
  always_comb begin
    alen    = cfg_mode[1] ? ((HCW'(cfg_pkt) + HCW'(1)) >> 1) : HCW'(cfg_pkt);
    act_s_d = HCW'(cfg_hsa) + HCW'(cfg_hbp);
    act_e_d = act_s_d + alen;
    hl      = HCW'(cfg_hline);
    err_d   = hl < act_e_d;
    len_d   = err_d ? act_e_d : hl;
    if (len_d == '0) len_d = HCW'(1);
    vsa_d   = (cfg_vsa > VSA_MAX) ? VSA_MAX : cfg_vsa;
    vas_d   = VCW'(vsa_d) + VCW'(cfg_vbp);
    vae_d   = vas_d + VCW'(cfg_vact);
    vtot_d  = vae_d + VCW'(cfg_vfp);
    if (vtot_d == '0) vtot_d = VCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hsa    <= '0;
      sh_act_s  <= '0;
      sh_act_e  <= '0;
      sh_len    <= HCW'(1);
      sh_err    <= 1'b0;
      sh_vsa    <= '0;
      sh_vact_s <= '0;
      sh_vact_e <= '0;
      sh_vtot   <= VCW'(1);
      sh_mode   <= VM_PULSE;
      sh_hs_low <= 1'b0;
      sh_vs_low <= 1'b0;
    end else if (load) begin
      sh_hsa    <= cfg_hsa;
      sh_act_s  <= act_s_d;
      sh_act_e  <= act_e_d;
      sh_len    <= len_d;
      sh_err    <= err_d;
      sh_vsa    <= vsa_d;
      sh_vact_s <= vas_d;
      sh_vact_e <= vae_d;
      sh_vtot   <= vtot_d;
      sh_mode   <= vmode_e'(cfg_mode);
      sh_hs_low <= cfg_hs_low;
      sh_vs_low <= cfg_vs_low;
    end
  end
endmodule

// File: rtl/vtg_wrapctr.sv
module vtg_wrapctr #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  logic [W-1:0] cnt_d;

  assign at_last = (cnt == limit - W'(1));

  always_comb begin
    cnt_d = cnt;
    if (!run)         cnt_d = '0;
    else if (step)    cnt_d = at_last ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && step && at_last |=> cnt == '0);
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [HW-1:0] cfg_hsa,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hline,
  input  logic [VW-1:0] cfg_vsa,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vfp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [PW-1:0] cfg_pkt,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_hs_low,
  input  logic          cfg_vs_low,
  output logic          frame_start_o,
  output logic          line_start_o,
  output logic          hs_start_o,
  output logic          hs_end_o,
  output logic          vs_start_o,
  output logic          vs_end_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          pix_valid_o,
  output logic [PW-1:0] pix_cnt_o,
  output logic          blank_o,
  output logic          cfg_err_o
);
  localparam int HCW = HW + 2;
  localparam int VCW = VW + 2;

  logic           active_q, active_d, load, run;
  logic [HW-1:0]  sh_hsa;
  logic [HCW-1:0] sh_act_s, sh_act_e, sh_len;
  logic           sh_err, sh_hs_low, sh_vs_low;
  logic [VW-1:0]  sh_vsa;
  logic [VCW-1:0] sh_vact_s, sh_vact_e, sh_vtot;
  vmode_e         sh_mode;
  logic [HCW-1:0] h_cnt, h_off, h_off_sc;
  logic [VCW-1:0] v_cnt;
  logic           h_last, v_last, h_in_act, v_in_act, evt, h_zero;

  always_comb begin
    active_d = enable;
    run      = active_q & enable;
    load     = enable & (~active_q | (h_last & v_last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  vtg_shadow #(.HW(HW), .VW(VW), .PW(PW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hline(cfg_hline),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp), .cfg_vact(cfg_vact),
    .cfg_pkt(cfg_pkt), .cfg_mode(cfg_mode),
    .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low),
    .sh_hsa(sh_hsa), .sh_act_s(sh_act_s), .sh_act_e(sh_act_e), .sh_len(sh_len),
    .sh_err(sh_err), .sh_vsa(sh_vsa), .sh_vact_s(sh_vact_s), .sh_vact_e(sh_vact_e),
    .sh_vtot(sh_vtot), .sh_mode(sh_mode), .sh_hs_low(sh_hs_low), .sh_vs_low(sh_vs_low)
  );

  vtg_wrapctr #(.W(HCW)) u_hctr (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
    .limit(sh_len), .cnt(h_cnt), .at_last(h_last)
  );

  vtg_wrapctr #(.W(VCW)) u_vctr (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_last),
    .limit(sh_vtot), .cnt(v_cnt), .at_last(v_last)
  );

  // region decode
  always_comb begin
    evt      = (sh_mode == VM_EVENT);
    h_zero   = (h_cnt == '0);
    h_in_act = (h_cnt >= sh_act_s) && (h_cnt < sh_act_e);
    v_in_act = (v_cnt >= sh_vact_s) && (v_cnt < sh_vact_e);
    h_off    = h_cnt - sh_act_s;
    h_off_sc = sh_mode[1] ? (h_off << 1) : h_off;

    line_start_o  = active_q & h_zero;
    frame_start_o = line_start_o & (v_cnt == '0);
    hs_start_o    = line_start_o;
    vs_start_o    = frame_start_o;
    hs_end_o      = active_q & ~evt & (h_cnt == HCW'(sh_hsa));
    vs_end_o      = line_start_o & ~evt & (v_cnt == VCW'(sh_vsa));
    pix_valid_o   = active_q & h_in_act & v_in_act;
    pix_cnt_o     = pix_valid_o ? h_off_sc[PW-1:0] : '0;
    blank_o       = active_q & ~(h_in_act & v_in_act);
    cfg_err_o     = active_q & sh_err;
    hsync_o       = active_q ? ((h_cnt < HCW'(sh_hsa)) ^ sh_hs_low) : cfg_hs_low;
    vsync_o       = active_q ? ((v_cnt < VCW'(sh_vsa)) ^ sh_vs_low) : cfg_vs_low;
  end

  // R3
  h_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> h_cnt < sh_len);

  // R4
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o && $past(pix_valid_o) && !line_start_o |->
      pix_cnt_o == $past(pix_cnt_o) + (sh_mode[1] ? PW'(2) : PW'(1)));

  // R7
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> $past(!active_q) || $past(h_last && v_last));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !frame_start_o |-> $stable(sh_len) && $stable(sh_vtot));

  // R11
  zero_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && sh_err && h_last && v_in_act |-> pix_valid_o);
endmodule

// File: tb/vid_timing_gen_test.sv
module vid_timing_gen_test;
  localparam int HW = 12, VW = 11, PW = 12;
  localparam int NV = 5;
  // hsa hbp hline vsa vbp vfp vact pkt mode | L lines beats hse vse err
  localparam int VEC [NV][15] = '{
    '{2, 3, 20, 2, 1, 1, 3, 8, 0,   20, 7, 24, 7, 1, 0},
    '{2, 3, 20, 2, 1, 1, 3, 8, 1,   20, 7, 24, 0, 0, 0},
    '{2, 3, 20, 2, 1, 1, 3, 9, 2,   20, 7, 15, 7, 1, 0},
    '{3, 4, 10, 1, 1, 1, 2, 6, 0,   13, 5, 12, 5, 1, 1},
    '{1, 1, 8, 20, 0, 0, 1, 4, 0,   8, 16, 4, 16, 1, 0}
  };

  logic clk = 0, rst_n = 0, enable = 0;
  logic [HW-1:0] cfg_hsa = '0, cfg_hbp = '0, cfg_hline = '0;
  logic [VW-1:0] cfg_vsa = '0, cfg_vbp = '0, cfg_vfp = '0, cfg_vact = '0;
  logic [PW-1:0] cfg_pkt = '0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_hs_low = 0, cfg_vs_low = 0;
  logic frame_start_o, line_start_o, hs_start_o, hs_end_o, vs_start_o, vs_end_o;
  logic hsync_o, vsync_o, pix_valid_o, blank_o, cfg_err_o;
  logic [PW-1:0] pix_cnt_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vid_timing_gen #(.HW(HW), .VW(VW), .PW(PW)) uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_vec(input int i);
    cfg_hsa = HW'(VEC[i][0]); cfg_hbp = HW'(VEC[i][1]); cfg_hline = HW'(VEC[i][2]);
    cfg_vsa = VW'(VEC[i][3]); cfg_vbp = VW'(VEC[i][4]); cfg_vfp = VW'(VEC[i][5]);
    cfg_vact = VW'(VEC[i][6]); cfg_pkt = PW'(VEC[i][7]); cfg_mode = 2'(VEC[i][8]);
  endtask

  task automatic start_run();
    enable = 0;
    repeat (2) @(negedge clk);
    enable = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg_hs_low = 1; cfg_vs_low = 1; enable = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "frame_start in reset", int'(frame_start_o), 0);
    check("R1", "pix_valid in reset", int'(pix_valid_o), 0);
    check("R1", "hsync idle level", int'(hsync_o), 1);
    enable = 0;
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1", "line_start disabled", int'(line_start_o), 0);
    check("R1", "vsync idle level", int'(vsync_o), 1);
    check("R1", "blank disabled", int'(blank_o), 0);

    // R9 / R2 / R7 polarity and sync placement
    load_vec(0);
    start_run();
    check("R7", "frame_start at origin", int'(frame_start_o), 1);
    check("R9", "hsync active-low in sync", int'(hsync_o), 0);
    check("R9", "vsync active-low in sync", int'(vsync_o), 0);
    check("R4", "blank in sync region", int'(blank_o), 1);
    repeat (2) @(negedge clk);
    check("R2", "hs_end at h=HSA", int'(hs_end_o), 1);
    check("R9", "hsync released after HSA", int'(hsync_o), 1);
    cfg_hs_low = 0; cfg_vs_low = 0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      int n, lines, beats, hse, vse, hsc, vsc, err, bad, llen, epc, step, vsat;
      bit seen;
      load_vec(i);
      start_run();
      n = 0; lines = 0; beats = 0; hse = 0; vse = 0; hsc = 0; vsc = 0;
      err = 0; bad = 0; llen = 0; epc = 0; seen = 0;
      step = (VEC[i][8] >= 2) ? 2 : 1;
      while (!(seen && frame_start_o) && n < 5000) begin
        if (frame_start_o) seen = 1;
        if (line_start_o) begin
          lines++; epc = 0;
          if (lines == 2) llen = n;
        end
        if (pix_valid_o) begin
          if (int'(pix_cnt_o) != epc) bad++;
          epc += step; beats++;
        end
        hse += int'(hs_end_o); vse += int'(vs_end_o);
        hsc += int'(hsync_o); vsc += int'(vsync_o);
        err |= int'(cfg_err_o);
        n++;
        @(negedge clk);
      end
      vsat = (VEC[i][3] > 15) ? 15 : VEC[i][3];
      check("R3", $sformatf("vec%0d line length", i), llen, VEC[i][9]);
      check("R3", $sformatf("vec%0d frame cycles", i), n, VEC[i][9] * VEC[i][10]);
      check("R7", $sformatf("vec%0d lines per frame", i), lines, VEC[i][10]);
      check(step == 2 ? "R5" : "R4", $sformatf("vec%0d payload beats", i), beats, VEC[i][11]);
      check(step == 2 ? "R5" : "R4", $sformatf("vec%0d pixel index errors", i), bad, 0);
      check(VEC[i][8] == 1 ? "R6" : "R2", $sformatf("vec%0d hs_end count", i), hse, VEC[i][12]);
      check(VEC[i][8] == 1 ? "R6" : "R7", $sformatf("vec%0d vs_end count", i), vse, VEC[i][13]);
      check("R11", $sformatf("vec%0d error flag", i), err, VEC[i][14]);
      check("R2", $sformatf("vec%0d hsync cycles", i), hsc, VEC[i][0] * VEC[i][10]);
      check("R8", $sformatf("vec%0d vsync cycles", i), vsc, vsat * VEC[i][9]);
    end

    // R10 mid-frame change of line period
    begin
      int n, m;
      load_vec(0);
      start_run();
      n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 25) cfg_hline = HW'(30);
      end while (!frame_start_o && n < 1000);
      check("R10", "old frame length kept", n, 140);
      m = 0;
      do begin
        @(negedge clk); m++;
      end while (!line_start_o && m < 1000);
      check("R10", "new line length next frame", m, 30);
    end

    enable = 0;
    @(negedge clk); @(negedge clk);
    check("R1", "pix_valid after disable", int'(pix_valid_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule